// File: doc/BRIEF.md
# Spectral Harmonic Analysis Sequencer

This block walks a stored one-sided magnitude spectrum and reduces it to the linear power figures from which dynamic-performance numbers such as SNR, SNDR and THD are later derived. The spectrum of N/2 bins sits in an external memory that the block reads through one read port with one clock of latency. After a start pulse the block latches the sampling frequency, the input frequency and a noise-classification threshold. It then evaluates the fundamental and eight harmonics one at a time, and finally makes one pass over the whole spectrum to gather total power, the DC value and the largest spur.

For every harmonic index the block folds the harmonic frequency into the first Nyquist zone and converts it to an expected bin with a shift-and-subtract divider. It searches a small window around that bin for the peak, then walks downhill on each side to find where the tone ends, and sums the squared magnitudes between those limits. Peaks already claimed by an earlier index are not counted again. Harmonics whose shape looks like noise are kept out of the harmonic total. The results are linear power sums and bin indices. Logarithms and ratios are left to the consumer. Results stay valid and stable while done is high.

Top module: `harm_analyzer`

## Requirements
- R1: While and directly after reset, busy, done and rd_en are low and every result output is zero.
- R2: For index i (1..9), the folded frequency h is (i·fin mod fs), replaced by fs−h when 2h > fs (fin < fs is required). The expected bin is floor(N·h/fs), limited to N/2−1. The peak is the largest magnitude in bins max(e−5,1)..min(e+5,N/2−1), and a tie goes to the lowest bin. fund_bin reports the peak for i = 1.
- R3: The lower limit steps down from the peak while the next lower bin is strictly smaller, and it stops at bin 1. The upper limit steps up in the same way and stops at bin N/2−1. fund_lo and fund_hi report these limits for the fundamental.
- R4: sig_pwr equals twice the sum of squared magnitudes from fund_lo to fund_hi.
- R5: harm_pwr is the sum of the tone powers (defined as in R4) of indices 2..9. An index whose peak bin equals the peak bin of any lower index adds nothing.
- R6: A harmonic with range sum S, peak P and width W = hi−lo+1 adds to harm_pwr only if (S−P)·256 > thresh_in·W·P. thresh_in is unsigned with 8 fractional bits.
- R7: total_pwr equals twice the sum of squared magnitudes of bins 1..N/2−1. dc_val equals the magnitude of bin 0 (address 0 holds DC).
- R8: spur_mag and spur_bin give the largest magnitude among bins 1..N/2−1 that lie outside fund_lo..fund_hi, with a tie going to the lowest bin. Both are zero when no such bin is above zero.
- R9: nd_pwr equals total_pwr − sig_pwr. noise_pwr equals nd_pwr − harm_pwr, and it is zero if harm_pwr exceeds nd_pwr.
- R10: done rises once the run ends. done and every result stay unchanged until the next accepted start. A start while busy is ignored, and busy and done are never high together.
- R11: rd_en is never high on two consecutive cycles. rd_data is taken one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when not busy |
| fs_in | input | FW | Sampling frequency, integer units |
| fin_in | input | FW | Input tone frequency, same units, below fs_in |
| thresh_in | input | TW | Noise-classification threshold, 8 fractional bits |
| rd_en | output | 1 | Spectrum memory read strobe |
| rd_addr | output | LOG2N-1 | Spectrum bin address |
| rd_data | input | MW | Magnitude returned one cycle after rd_en |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid and held |
| dc_val | output | MW | Magnitude of bin 0 |
| fund_bin | output | LOG2N-1 | Fundamental peak bin |
| fund_lo | output | LOG2N-1 | Fundamental lower limit |
| fund_hi | output | LOG2N-1 | Fundamental upper limit |
| sig_pwr | output | 2MW+LOG2N+1 | Signal power |
| harm_pwr | output | 2MW+LOG2N+1 | Accepted harmonic power |
| total_pwr | output | 2MW+LOG2N+1 | Power of all non-DC bins |
| nd_pwr | output | 2MW+LOG2N+1 | Noise plus distortion power |
| noise_pwr | output | 2MW+LOG2N+1 | Noise power |
| spur_bin | output | LOG2N-1 | Bin of the largest spur |
| spur_mag | output | MW | Magnitude of the largest spur |

## Verification
Most internal errors in this sequencer show up at the end of one run, through the few words it reports. A wrong fold or divider step moves the search window, so fund_bin or harm_pwr changes when done rises. A bad valley walk changes fund_lo or fund_hi, and through them sig_pwr, the spur search and nd_pwr. A slip in the final pass shows in total_pwr or dc_val. A broken hold or restart rule shows within a few cycles of done, when the held results change or a second start takes effect.

// File: rtl/harm_pkg.sv
package harm_pkg;

    localparam int PEAK_SPAN = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FOLD,
        ST_DIV,
        ST_PK_RD,
        ST_PK_WT,
        ST_LO_RD,
        ST_LO_WT,
        ST_HI_RD,
        ST_HI_WT,
        ST_SUM_RD,
        ST_SUM_WT,
        ST_ACC,
        ST_TOT_RD,
        ST_TOT_WT,
        ST_FIN
    } seq_state_t;

endpackage

// File: rtl/harm_bin_locator.sv
module harm_bin_locator #(
    parameter int FW    = 24,
    parameter int LOG2N = 6,
    parameter int AW    = LOG2N - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          go,
    input  logic [FW-1:0] fs,
    input  logic [FW-1:0] fin,
    output logic          valid,
    output logic [AW-1:0] bin
);
    localparam int NB = 1 << AW;
    localparam int CW = $clog2(LOG2N) + 1;

    logic [FW:0]      hacc;
    logic [FW:0]      hsum, hmod, hfold;
    logic [FW+1:0]    rem, rem_sh, rem_nx;
    logic [LOG2N-1:0] quo;
    logic [CW-1:0]    cnt;
    logic             running;
    logic             ge;

    // running residue of i*fin modulo fs, then fold about fs/2
    always_comb begin
        hsum  = hacc + {1'b0, fin};
        hmod  = (hsum >= {1'b0, fs}) ? hsum - {1'b0, fs} : hsum;
        hfold = ({hmod, 1'b0} > {2'b0, fs}) ? {1'b0, fs} - hmod : hmod;
    end

    // one restoring-division step per cycle
    always_comb begin
        rem_sh = rem << 1;
        ge     = rem_sh >= {2'b0, fs};
        rem_nx = ge ? rem_sh - {2'b0, fs} : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hacc    <= '0;
            rem     <= '0;
            quo     <= '0;
            cnt     <= '0;
            running <= 1'b0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (clear) begin
                hacc <= '0;
            end else if (go) begin
                hacc    <= hmod;
                rem     <= {1'b0, hfold};
                quo     <= '0;
                cnt     <= '0;
                running <= 1'b1;
            end else if (running) begin
                rem <= rem_nx;
                quo <= {quo[LOG2N-2:0], ge};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(LOG2N - 1)) begin
                    running <= 1'b0;
                    valid   <= 1'b1;
                end
            end
        end
    end

    assign bin = (quo > LOG2N'(NB - 1)) ? AW'(NB - 1) : quo[AW-1:0];

    AST_QUOTIENT_BOUND: assert property (@(posedge clk) disable iff (rst)
        valid |-> (quo <= LOG2N'(NB))) else $error("quotient beyond half band"); // R2

endmodule

// File: rtl/harm_ratio_check.sv
module harm_ratio_check #(
    parameter int MW = 16,
    parameter int AW = 5,
    parameter int SW = MW + AW + 1,
    parameter int TW = 16,
    parameter int TF = 8
) (
    input  logic [SW-1:0] sum_lin,
    input  logic [MW-1:0] peak,
    input  logic [AW:0]   width,
    input  logic [TW-1:0] thr,
    output logic          keep
);
    localparam int RW = TW + MW + AW + 2;

    logic [RW-1:0] lhs, rhs;

    always_comb begin
        lhs  = RW'(sum_lin - SW'(peak)) << TF;
        rhs  = RW'(thr) * RW'(width) * RW'(peak);
        keep = lhs > rhs;
    end

endmodule

// File: rtl/harm_analyzer.sv
module harm_analyzer
    import harm_pkg::*;
#(
    parameter int LOG2N = 6,
    parameter int MW    = 16,
    parameter int FW    = 24,
    parameter int TW    = 16,
    parameter int TF    = 8,
    parameter int NH    = 9,
    parameter int AW    = LOG2N - 1,
    parameter int PW    = 2 * MW + LOG2N + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [FW-1:0] fs_in,
    input  logic [FW-1:0] fin_in,
    input  logic [TW-1:0] thresh_in,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [MW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic [MW-1:0] dc_val,
    output logic [AW-1:0] fund_bin,
    output logic [AW-1:0] fund_lo,
    output logic [AW-1:0] fund_hi,
    output logic [PW-1:0] sig_pwr,
    output logic [PW-1:0] harm_pwr,
    output logic [PW-1:0] total_pwr,
    output logic [PW-1:0] nd_pwr,
    output logic [PW-1:0] noise_pwr,
    output logic [AW-1:0] spur_bin,
    output logic [MW-1:0] spur_mag
);
    localparam int NB = 1 << AW;
    localparam int SW = MW + AW + 1;
    localparam int HW = $clog2(NH + 1);
    localparam logic [AW-1:0] LAST = AW'(NB - 1);
    localparam logic [AW-1:0] ONE  = AW'(1);

    seq_state_t    state;
    logic [FW-1:0] fs_r, fin_r;
    logic [TW-1:0] thr_r;
    logic [HW-1:0] hidx;
    logic [AW-1:0] whi, ptr, pk_bin, cur, lo, hi;
    logic [MW-1:0] pk_mag, cur_mag;
    logic [PW-1:0] sum_sq;
    logic [SW-1:0] sum_lin;
    logic [AW-1:0] pk_hist [NH];

    logic          accept, loc_go, loc_valid, keep, dup;
    logic [AW-1:0] loc_bin, wlo_c, whi_c, np_bin;
    logic [AW:0]   span_ext, width;
    logic [MW-1:0] np_mag;
    logic [2*MW-1:0] sq;
    logic [PW-1:0] dsq, tot_nx, nd_nx;

    assign busy   = (state != ST_IDLE) && (state != ST_FIN);
    assign accept = start && !busy;
    assign loc_go = (state == ST_FOLD);

    harm_bin_locator #(.FW(FW), .LOG2N(LOG2N), .AW(AW)) u_loc (
        .clk(clk), .rst(rst), .clear(accept), .go(loc_go),
        .fs(fs_r), .fin(fin_r), .valid(loc_valid), .bin(loc_bin)
    );

    harm_ratio_check #(.MW(MW), .AW(AW), .SW(SW), .TW(TW), .TF(TF)) u_ratio (
        .sum_lin(sum_lin), .peak(pk_mag), .width(width), .thr(thr_r), .keep(keep)
    );

    // shared squarer, search window, and peak update
    always_comb begin
        sq       = rd_data * rd_data;
        dsq      = PW'({sq, 1'b0});
        span_ext = {1'b0, loc_bin} + (AW+1)'(PEAK_SPAN);
        wlo_c    = (loc_bin >= AW'(PEAK_SPAN + 1)) ? loc_bin - AW'(PEAK_SPAN) : ONE;
        whi_c    = (span_ext > (AW+1)'(NB - 1)) ? LAST : span_ext[AW-1:0];
        np_bin   = (rd_data > pk_mag) ? ptr : pk_bin;
        np_mag   = (rd_data > pk_mag) ? rd_data : pk_mag;
        width    = {1'b0, hi} - {1'b0, lo} + 1'b1;
        tot_nx   = (ptr == '0) ? total_pwr : total_pwr + dsq;
        nd_nx    = tot_nx - sig_pwr;
    end

    always_comb begin
        dup = 1'b0;
        for (int j = 0; j < NH; j++)
            if ((j < int'(hidx) - 1) && (pk_hist[j] == pk_bin)) dup = 1'b1;
    end

    // memory port: one read in flight, data used in the following *_WT state
    always_comb begin
        rd_en   = 1'b0;
        rd_addr = '0;
        case (state)
            ST_PK_RD, ST_SUM_RD, ST_TOT_RD: begin rd_en = 1'b1; rd_addr = ptr; end
            ST_LO_RD: begin rd_en = (cur != ONE);  rd_addr = cur - ONE; end
            ST_HI_RD: begin rd_en = (cur != LAST); rd_addr = cur + ONE; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            fs_r <= '0; fin_r <= '0; thr_r <= '0; hidx <= '0;
            whi <= '0; ptr <= '0; pk_bin <= '0; pk_mag <= '0;
            cur <= '0; cur_mag <= '0; lo <= '0; hi <= '0;
            sum_sq <= '0; sum_lin <= '0;
            for (int j = 0; j < NH; j++) pk_hist[j] <= '0;
            done <= 1'b0; dc_val <= '0;
            fund_bin <= '0; fund_lo <= '0; fund_hi <= '0;
            sig_pwr <= '0; harm_pwr <= '0; total_pwr <= '0;
            nd_pwr <= '0; noise_pwr <= '0; spur_bin <= '0; spur_mag <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_FIN: if (accept) begin
                    fs_r <= fs_in; fin_r <= fin_in; thr_r <= thresh_in;
                    hidx <= HW'(1); done <= 1'b0; dc_val <= '0;
                    fund_bin <= '0; fund_lo <= '0; fund_hi <= '0;
                    sig_pwr <= '0; harm_pwr <= '0; total_pwr <= '0;
                    nd_pwr <= '0; noise_pwr <= '0; spur_bin <= '0; spur_mag <= '0;
                    state <= ST_FOLD;
                end
                ST_FOLD: state <= ST_DIV;
                ST_DIV: if (loc_valid) begin
                    ptr <= wlo_c; whi <= whi_c;
                    pk_bin <= wlo_c; pk_mag <= '0;
                    state <= ST_PK_RD;
                end
                ST_PK_RD: state <= ST_PK_WT;
                ST_PK_WT: begin
                    pk_bin <= np_bin; pk_mag <= np_mag;
                    if (ptr == whi) begin
                        cur <= np_bin; cur_mag <= np_mag;
                        state <= ST_LO_RD;
                    end else begin
                        ptr <= ptr + ONE;
                        state <= ST_PK_RD;
                    end
                end
                ST_LO_RD: if (cur == ONE) begin
                    lo <= cur; cur <= pk_bin; cur_mag <= pk_mag;
                    state <= ST_HI_RD;
                end else state <= ST_LO_WT;
                ST_LO_WT: if (rd_data < cur_mag) begin
                    cur <= cur - ONE; cur_mag <= rd_data;
                    state <= ST_LO_RD;
                end else begin
                    lo <= cur; cur <= pk_bin; cur_mag <= pk_mag;
                    state <= ST_HI_RD;
                end
                ST_HI_RD: if (cur == LAST) begin
                    hi <= cur; ptr <= lo; sum_sq <= '0; sum_lin <= '0;
                    state <= ST_SUM_RD;
                end else state <= ST_HI_WT;
                ST_HI_WT: if (rd_data < cur_mag) begin
                    cur <= cur + ONE; cur_mag <= rd_data;
                    state <= ST_HI_RD;
                end else begin
                    hi <= cur; ptr <= lo; sum_sq <= '0; sum_lin <= '0;
                    state <= ST_SUM_RD;
                end
                ST_SUM_RD: state <= ST_SUM_WT;
                ST_SUM_WT: begin
                    sum_sq  <= sum_sq + PW'(sq);
                    sum_lin <= sum_lin + SW'(rd_data);
                    if (ptr == hi) state <= ST_ACC;
                    else begin
                        ptr <= ptr + ONE;
                        state <= ST_SUM_RD;
                    end
                end
                ST_ACC: begin
                    pk_hist[hidx - 1'b1] <= pk_bin;
                    if (hidx == HW'(1)) begin
                        sig_pwr <= sum_sq << 1;
                        fund_bin <= pk_bin; fund_lo <= lo; fund_hi <= hi;
                    end else if (!dup && keep) begin
                        harm_pwr <= harm_pwr + (sum_sq << 1);
                    end
                    if (hidx == HW'(NH)) begin
                        ptr <= '0;
                        state <= ST_TOT_RD;
                    end else begin
                        hidx <= hidx + 1'b1;
                        state <= ST_FOLD;
                    end
                end
                ST_TOT_RD: state <= ST_TOT_WT;
                ST_TOT_WT: begin
                    if (ptr == '0) dc_val <= rd_data;
                    total_pwr <= tot_nx;
                    if (ptr != '0 && (ptr < fund_lo || ptr > fund_hi) && rd_data > spur_mag) begin
                        spur_mag <= rd_data; spur_bin <= ptr;
                    end
                    if (ptr == LAST) begin
                        nd_pwr    <= nd_nx;
                        noise_pwr <= (nd_nx > harm_pwr) ? nd_nx - harm_pwr : '0;
                        done      <= 1'b1;
                        state     <= ST_FIN;
                    end else begin
                        ptr <= ptr + ONE;
                        state <= ST_TOT_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_READ_SPACED: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en) else $error("back-to-back reads"); // R11
    AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACC) |-> (lo <= pk_bin && pk_bin <= hi && lo != '0)) else $error("range does not bracket peak"); // R3
    AST_SIG_IN_TOTAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (sig_pwr <= total_pwr)) else $error("signal exceeds total"); // R4
    AST_NOISE_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> (noise_pwr <= nd_pwr)) else $error("noise exceeds nd"); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> ($stable(sig_pwr) && $stable(harm_pwr) && $stable(noise_pwr)
                                   && $stable(spur_bin) && $stable(fund_bin))) else $error("results moved"); // R10
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)) else $error("busy with done"); // R10

endmodule

// File: tb/harm_analyzer_test.sv
module harm_analyzer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 32;
    localparam int NPTS = 64;

    typedef struct {
        string  tag;
        longint sig, harm, tot, nd, noise;
        int     dc, fb, flo, fhi, sb, sm;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] fs_in = '0, fin_in = '0;
    logic [15:0] thresh_in = '0;
    logic        rd_en, busy, done;
    logic [4:0]  rd_addr, fund_bin, fund_lo, fund_hi, spur_bin;
    logic [15:0] rd_data, dc_val, spur_mag;
    logic [38:0] sig_pwr, harm_pwr, total_pwr, nd_pwr, noise_pwr;
    logic [15:0] mem [NB];

    int n_chk = 0, n_bad = 0, rd_viol = 0, rd_cnt = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    harm_analyzer uut (
        .clk(clk), .rst(rst), .start(start), .fs_in(fs_in), .fin_in(fin_in),
        .thresh_in(thresh_in), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .dc_val(dc_val), .fund_bin(fund_bin),
        .fund_lo(fund_lo), .fund_hi(fund_hi), .sig_pwr(sig_pwr), .harm_pwr(harm_pwr),
        .total_pwr(total_pwr), .nd_pwr(nd_pwr), .noise_pwr(noise_pwr),
        .spur_bin(spur_bin), .spur_mag(spur_mag)
    );

    always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    logic rd_en_q = 1'b0;
    always @(posedge clk) begin
        if (rd_en && rd_en_q) rd_viol++;
        if (rd_en) rd_cnt++;
        rd_en_q <= rd_en;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---- spectrum builders ----
    task automatic fill_noise(input int seed);
        int s = seed;
        for (int b = 0; b < NB; b++) begin
            s = (s * 1103515245 + 12345) & 32'h7fffffff;
            mem[b] = 16'((s >> 16) & 3);
        end
    endtask

    task automatic put(input int b, input int v);
        if (b >= 1 && b < NB && int'(mem[b]) < v) mem[b] = 16'(v);
    endtask

    task automatic tone(input int c, input int amp);
        put(c, amp); put(c-1, amp/2); put(c+1, amp/2); put(c-2, amp/4); put(c+2, amp/4);
    endtask

    // ---- reference model written from the requirements ----
    function automatic exp_t model(input int fs, input int fin, input int thr, input string tag);
        exp_t e;
        int pks[9];
        int m[NB];
        e.tag = tag; e.sig = 0; e.harm = 0; e.tot = 0;
        for (int b = 0; b < NB; b++) m[b] = int'(mem[b]);
        for (int i = 1; i <= 9; i++) begin
            int h, eb, wl, wh, pk, lo, hi;
            longint ssq, sl, pw;
            bit dup;
            h = (i * fin) % fs;
            if (2 * h > fs) h = fs - h;
            eb = (h * NPTS) / fs;
            if (eb > NB-1) eb = NB-1;
            wl = (eb >= 6) ? eb - 5 : 1;                  // R2
            wh = (eb + 5 > NB-1) ? NB-1 : eb + 5;
            pk = wl;
            for (int b = wl; b <= wh; b++) if (m[b] > m[pk]) pk = b;
            lo = pk; while (lo > 1 && m[lo-1] < m[lo]) lo--;          // R3
            hi = pk; while (hi < NB-1 && m[hi+1] < m[hi]) hi++;
            ssq = 0; sl = 0;
            for (int b = lo; b <= hi; b++) begin ssq += longint'(m[b]) * m[b]; sl += m[b]; end
            pw = 2 * ssq;
            dup = 0;
            for (int j = 0; j < i-1; j++) if (pks[j] == pk) dup = 1;    // R5
            pks[i-1] = pk;
            if (i == 1) begin e.sig = pw; e.fb = pk; e.flo = lo; e.fhi = hi; end
            else if (!dup && (sl - m[pk]) * 256 > longint'(thr) * (hi - lo + 1) * m[pk]) e.harm += pw; // R6
        end
        e.dc = m[0]; e.sb = 0; e.sm = 0;
        for (int b = 1; b < NB; b++) begin
            e.tot += 2 * longint'(m[b]) * m[b];                       // R7
            if ((b < e.flo || b > e.fhi) && m[b] > e.sm) begin e.sm = m[b]; e.sb = b; end // R8
        end
        e.nd = e.tot - e.sig;                                           // R9
        e.noise = (e.nd > e.harm) ? e.nd - e.harm : 0;
        return e;
    endfunction

    // ---- driver ----
    task automatic run_case(input int fs, input int fin, input int thr, input string tag,
                            input bit interrupt);
        sb_q.push_back(model(fs, fin, thr, tag));
        @(negedge clk);
        fs_in = 24'(fs); fin_in = 24'(fin); thresh_in = 16'(thr); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (interrupt) begin
            repeat (20) @(negedge clk);
            fin_in = 24'(21); thresh_in = 16'hffff; start = 1'b1;   // R10: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    // ---- monitor / scoreboard ----
    task automatic compare(input exp_t e, input string sfx);
        check("R2", {e.tag, sfx, " fund_bin"}, fund_bin, e.fb);
        check("R3", {e.tag, sfx, " fund_lo"}, fund_lo, e.flo);
        check("R3", {e.tag, sfx, " fund_hi"}, fund_hi, e.fhi);
        check("R4", {e.tag, sfx, " sig_pwr"}, sig_pwr, e.sig);
        check(e.tag, {sfx, " harm_pwr"}, harm_pwr, e.harm);
        check("R7", {e.tag, sfx, " total_pwr"}, total_pwr, e.tot);
        check("R7", {e.tag, sfx, " dc_val"}, dc_val, e.dc);
        check("R8", {e.tag, sfx, " spur_bin"}, spur_bin, e.sb);
        check("R8", {e.tag, sfx, " spur_mag"}, spur_mag, e.sm);
        check("R9", {e.tag, sfx, " nd_pwr"}, nd_pwr, e.nd);
        check("R9", {e.tag, sfx, " noise_pwr"}, noise_pwr, e.noise);
    endtask

    initial begin
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            exp_t e;
            while (!done) @(negedge clk);
            if (sb_q.size() == 0) begin
                check("R10", "done without pending run", 1, 0);
            end else begin
                e = sb_q.pop_front();
                compare(e, "");
                repeat (4) @(negedge clk);
                check("R10", "done held", done, 1);
                check("R10", "busy low while done", busy, 0);
                compare(e, " held");
            end
            while (done) @(negedge clk);
        end
    end

    // ---- watchdog ----
    initial begin
        repeat (150000) @(posedge clk);
        check("WDOG", "run completed", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---- main sequence ----
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "rd_en", rd_en, 0);
        check("R1", "sig_pwr", sig_pwr, 0);
        check("R1", "total_pwr", total_pwr, 0);
        check("R1", "spur_mag", spur_mag, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy after release", busy, 0);

        // spectrum A: tone at 5 with harmonics, DC present
        fill_noise(7);
        mem[0] = 16'd77;
        tone(5, 1000); tone(10, 300); tone(15, 200); tone(20, 150); tone(25, 90); put(30, 60);
        run_case(64, 5, 0, "R5", 0);
        run_case(64, 5, 16'hffff, "R6", 0);
        run_case(64, 5, 16'h0040, "R6", 0);
        run_case(64, 5, 0, "R10", 1);

        // spectrum B: harmonics fold near DC and onto each other
        fill_noise(11);
        tone(21, 900); tone(22, 500); put(1, 80); tone(20, 120);
        run_case(64, 21, 0, "R5", 0);

        // top edge of the band and exactly half the sampling rate
        fill_noise(3);
        tone(31, 700); tone(2, 200); tone(29, 150);
        run_case(64, 31, 0, "R2", 0);
        run_case(64, 32, 0, "R2", 0);

        // flat spectrum: every range is a single bin
        for (int b = 0; b < NB; b++) mem[b] = 16'd7;
        run_case(64, 5, 0, "R3", 0);

        // descending ramp: fundamental range covers the whole band, no spur
        for (int b = 0; b < NB; b++) mem[b] = 16'(200 - 6 * b);
        run_case(64, 1, 0, "R8", 0);

        check("R11", "no back-to-back reads", rd_viol, 0);
        check("R11", "reads issued", (rd_cnt > 0) ? 1 : 0, 1);
        check("R10", "scoreboard drained", sb_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule